// File: doc/BRIEF.md
# Press Group Counter

This block takes an active-low push-button level that has already been synchronised to the clock and recognises each press. A press is a falling transition: on a rising clock edge the button is sampled low, and on the edge before it was sampled high. The block counts presses in groups of three. When a group is complete, an 8-bit event counter advances by one and the press tally starts again from zero.

Groups never overlap. Presses one to three form the first group and presses four to six form the second, so no press ever counts twice. A button held low for any number of cycles is a single press. The running tally is exposed next to the counter so that partial groups can be observed.

Top module: `press_group_counter`

## Requirements
- R1: While `rst_n` is low, `event_count` and `press_tally` are 0. The remembered button level is set to released (1), so a button that is already low when reset ends counts as a press on the first edge after reset.
- R2: A press is counted on a rising edge where `btn_n` is sampled 0 and the sample from the previous edge was 1. If that press is not the last of a group, `press_tally` rises by exactly one, and the new value is visible after that same edge.
- R3: A button held low across many edges counts as exactly one press.
- R4: The press that would bring the tally to three increments `event_count` by one and returns `press_tally` to 0 on that same edge. This is well inside two cycles after the third falling edge.
- R5: Groups are disjoint. Six presses advance `event_count` by exactly two, and any change of `event_count` is a step of +1 with `press_tally` at 0.
- R6: `event_count` wraps from 255 to 0 with no other indication.
- R7: An edge that samples `btn_n` high, including a rising button edge, changes neither output.
- R8: `press_tally` only takes the values 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_n | input | 1 | Synchronised button level, 0 = pressed |
| event_count | output | 8 | Completed groups of three presses, modulo 256 |
| press_tally | output | 2 | Presses counted in the current group |

## Verification
A wrong remembered button level shows up at the very next edge: `press_tally` either moves while the button is held or stays put on a real press. A tally that drifts out of step leaves `event_count` off by one at the end of the group, at most three presses later. A wrong increment or a missed wrap of the counter appears on the edge that completes a group. The bench compares both outputs against an independent model after every edge, so any of these faults is reported in the cycle it first becomes visible.

// File: rtl/press_group_counter.sv
module press_group_counter #(
  parameter int CNT_W   = 8,
  parameter int GROUP   = 3,
  parameter int TALLY_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               btn_n,
  output logic [CNT_W-1:0]   event_count,
  output logic [TALLY_W-1:0] press_tally
);
  localparam logic [TALLY_W-1:0] LAST = TALLY_W'(GROUP - 1);

  logic btn_q;
  logic hit;
  logic wrap;

  assign hit  = btn_q & ~btn_n;
  assign wrap = hit && (press_tally == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      btn_q       <= 1'b1;
      press_tally <= '0;
      event_count <= '0;
    end else begin
      btn_q <= btn_n;
      if (wrap) begin
        press_tally <= '0;
        event_count <= event_count + 1'b1;
      end else if (hit) begin
        press_tally <= press_tally + 1'b1;
      end
    end
  end
endmodule

// File: rtl/press_group_counter_chk.sv
module press_group_counter_chk #(
  parameter int CNT_W   = 8,
  parameter int TALLY_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               btn_n,
  input logic [CNT_W-1:0]   event_count,
  input logic [TALLY_W-1:0] press_tally
);
  // R8
  tally_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    press_tally != 2'd3);

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (event_count != $past(event_count)) |->
      (event_count == $past(event_count) + 1'b1) && (press_tally == 2'd0));

  // R7
  idle_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    btn_n |=> $stable(press_tally) && $stable(event_count));

  // R3
  held_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!btn_n && !$past(btn_n) && $past(rst_n)) |=>
      $stable(press_tally) && $stable(event_count));

  // R2
  press_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!btn_n && $past(btn_n) && $past(rst_n) && press_tally != 2'd2) |=>
      (press_tally == $past(press_tally) + 1'b1) && $stable(event_count));

  // R4
  group_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!btn_n && $past(btn_n) && $past(rst_n) && press_tally == 2'd2) |=>
      (press_tally == 2'd0) && (event_count == $past(event_count) + 1'b1));
endmodule

bind press_group_counter press_group_counter_chk #(.CNT_W(CNT_W), .TALLY_W(TALLY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .btn_n(btn_n),
  .event_count(event_count), .press_tally(press_tally));

// File: tb/press_group_counter_test.sv
module press_group_counter_test;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       btn_n = 1'b1;
  logic [7:0] event_count;
  logic [1:0] press_tally;

  int checks = 0;
  int fails  = 0;
  string phase = "R1";

  int m_prev  = 1;
  int m_tally = 0;
  int m_count = 0;

  always #(PERIOD/2) clk = ~clk;

  press_group_counter uut (
    .clk(clk), .rst_n(rst_n), .btn_n(btn_n),
    .event_count(event_count), .press_tally(press_tally));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev = 1; m_tally = 0; m_count = 0;
    end else begin
      if (m_prev == 1 && btn_n == 1'b0) begin
        m_tally = m_tally + 1;
        if (m_tally == 3) begin
          m_tally = 0;
          m_count = (m_count + 1) % 256;
        end
      end
      m_prev = btn_n;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always begin
    @(posedge clk);
    #1;
    check({phase, " count"}, int'(event_count), m_count);
    check({phase, " tally"}, int'(press_tally), m_tally);
  end

  task automatic press(int hold, int gap);
    @(negedge clk); btn_n = 1'b0;
    repeat (hold - 1) @(negedge clk);
    @(negedge clk); btn_n = 1'b1;
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(PERIOD*200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: reset state with button held low
    btn_n = 1'b0;
    idle(3);
    check("R1 reset count", int'(event_count), 0);
    check("R1 reset tally", int'(press_tally), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 low at release counts", int'(press_tally), 1);
    btn_n = 1'b1;
    idle(2);

    // R2: single press steps tally
    phase = "R2";
    press(1, 2);
    check("R2 tally after press", int'(press_tally), 2);

    // R4: third press completes group
    phase = "R4";
    press(1, 2);
    check("R4 count after group", int'(event_count), 1);
    check("R4 tally cleared", int'(press_tally), 0);

    // R3: long hold counts once
    phase = "R3";
    press(20, 3);
    check("R3 long hold tally", int'(press_tally), 1);

    // R7: idle high, no change
    phase = "R7";
    idle(10);
    check("R7 idle tally", int'(press_tally), 1);
    check("R7 idle count", int'(event_count), 1);

    // R5: six more presses -> two groups exactly
    phase = "R5";
    press(1, 1); press(1, 1);
    check("R5 after finishing group", int'(event_count), 2);
    repeat (6) press(2, 1);
    check("R5 six presses", int'(event_count), 4);
    check("R5 tally", int'(press_tally), 0);

    // R6: wrap
    phase = "R6";
    repeat (251 * 3) press(1, 1);
    check("R6 at 255", int'(event_count), 255);
    repeat (3) press(1, 1);
    check("R6 wrapped", int'(event_count), 0);

    // R1: async reset mid-group
    phase = "R1";
    press(1, 1);
    @(negedge clk); rst_n = 1'b0;
    idle(2);
    check("R1 mid reset tally", int'(press_tally), 0);
    rst_n = 1'b1;
    idle(2);

    // R8: many patterns, tally bounded (checked every edge too)
    phase = "R8";
    for (int i = 0; i < 20; i++) press(1 + (i % 4), 1 + (i % 3));
    check("R8 tally range", int'(press_tally <= 2), 1);

    idle(3);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule